// File: doc/BRIEF.md
# Saturating Bidirectional Word Shifter

This block executes one of four shift operations on the low 32 bits of a source register and returns a 32-bit result that is sign-extended to the full register width. It decodes the instruction word itself. Two bidirectional forms read a signed 6-bit shift amount from the shift operand. A non-negative amount shifts left with saturation. A negative amount shifts arithmetically right by its magnitude, and one of the two forms rounds that right shift. Two left-only forms take a 5-bit amount, either from the shift operand or from the immediate field of the instruction.

A left shift that leaves the signed 32-bit range is clamped to the nearest limit. In that case the block raises a one-cycle saturation pulse, which the surrounding core can OR into its sticky status bit. The result and the pulse appear one clock after the operation is presented. When the instruction word is not one of the four forms, the block reports a miss and drives a zero result.

Top module: `sat_word_shifter`

## Requirements
- R1: An operation is recognised only when insn[6:0] = 1110111 and insn[14:12] = 001, with insn[31:25] equal to 0110111 (bidirectional, truncating), 0111111 (bidirectional, rounding), 0010011 (left-only, amount from register) or 0011011 (left-only, amount from immediate). For any other word with in_valid high, out_hit, out_sat and out_result are all zero.
- R2: out_valid, out_hit, out_result and out_sat reflect the operation presented in the previous clock cycle. Reset clears all of them to zero, and a cycle with in_valid low produces out_valid = 0, out_hit = 0 and out_sat = 0.
- R3: In both bidirectional forms the amount is shamt_src[5:0] read as two's complement (-32 to 31). Bits above bit 5 have no effect.
- R4: A left shift computes src_word[31:0] times 2^amount in a wide intermediate. If that value lies outside [-2^31, 2^31-1], the result becomes 0x7FFFFFFF or 0x80000000 (toward the sign of the source) and out_sat is 1. Otherwise out_sat is 0.
- R5: In the truncating bidirectional form, a negative amount gives an arithmetic right shift by its magnitude, with a magnitude of 32 treated as 31. Right shifts never raise out_sat.
- R6: In the rounding bidirectional form, a right shift by n returns floor((x + 2^(n-1)) / 2^n), computed without overflow. The magnitude 32 is also treated as 31 here.
- R7: The left-only register form uses shamt_src[4:0]. The immediate form uses insn[24:20] and ignores shamt_src completely.
- R8: Only src_word[31:0] is used, and out_result[63:32] copies out_result[31] for every recognised operation.
- R9: out_sat is high only in a cycle where out_valid and out_hit are high. It is one pulse per clamping operation, so back-to-back clamping operations give one pulse each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| insn | input | 32 | Instruction word to decode |
| src_word | input | XLEN (64) | Value to shift (low 32 bits used) |
| shamt_src | input | XLEN (64) | Register shift operand |
| out_valid | output | 1 | Registered copy of in_valid |
| out_hit | output | 1 | The registered operation was one of the four forms |
| out_result | output | XLEN (64) | Sign-extended 32-bit result |
| out_sat | output | 1 | Saturation pulse for the sticky status bit |

## Verification
The hardest cases to reach are at the edges of the shift ranges. One is an amount field of exactly 100000, which must be clamped to a right shift of 31 and rounded from the most extreme sources. The other is a left shift whose result lands exactly on -2^31, which must not saturate. Random operands almost never produce these, so directed operations set them up: 0x80000000 and 0x7FFFFFFF at magnitude 32 in both forms, and -1 shifted left by 31. These are followed by a randomised stream over all forms, with garbage in the upper operand bits and in unrelated instruction fields.

// File: rtl/sws_pkg.sv
package sws_pkg;

    localparam logic [6:0] SWS_OPCODE   = 7'b1110111;
    localparam logic [2:0] SWS_FUNCT3   = 3'b001;
    localparam logic [6:0] SWS_F7_BID   = 7'b0110111;
    localparam logic [6:0] SWS_F7_BIDR  = 7'b0111111;
    localparam logic [6:0] SWS_F7_LREG  = 7'b0010011;
    localparam logic [6:0] SWS_F7_LIMM  = 7'b0011011;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_BIDIR,
        OP_BIDIR_RND,
        OP_LEFT_REG,
        OP_LEFT_IMM
    } sws_op_e;

    typedef struct packed {
        logic        vld;
        logic        hit;
        logic        sat;
        logic [31:0] word;
    } sws_state_t;

endpackage

// File: rtl/sws_decode.sv
module sws_decode
    import sws_pkg::*;
(
    input  logic [31:0] insn,
    output sws_op_e     op,
    output logic [4:0]  imm5
);
    logic unused_fields;
    assign unused_fields = ^{insn[19:15], insn[11:7]};
    assign imm5 = insn[24:20];

    always_comb begin
        op = OP_NONE;
        if (insn[6:0] == SWS_OPCODE && insn[14:12] == SWS_FUNCT3) begin
            unique case (insn[31:25])
                SWS_F7_BID:  op = OP_BIDIR;
                SWS_F7_BIDR: op = OP_BIDIR_RND;
                SWS_F7_LREG: op = OP_LEFT_REG;
                SWS_F7_LIMM: op = OP_LEFT_IMM;
                default:     op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/sws_left_sat.sv
module sws_left_sat #(
    parameter int W = 32,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  val,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  res,
    output logic          sat
);
    logic [2*W-1:0] wide;
    logic [W:0]     upper;

    assign wide  = {{W{val[W-1]}}, val} << amt;
    assign upper = wide[2*W-1:W-1];
    assign sat   = !((&upper) || !(|upper));

    always_comb begin
        if (!sat)
            res = wide[W-1:0];
        else if (val[W-1])
            res = {1'b1, {(W-1){1'b0}}};
        else
            res = {1'b0, {(W-1){1'b1}}};
    end
endmodule

// File: rtl/sws_right_shift.sv
module sws_right_shift #(
    parameter int W = 32,
    localparam int SW = $clog2(W) + 1
) (
    input  logic [W-1:0]  val,
    input  logic [SW-1:0] mag,
    input  logic          rnd,
    output logic [W-1:0]  res
);
    logic [SW-1:0]   n;
    logic signed [W:0] ext;
    logic signed [W:0] bias;
    logic signed [W:0] sum;
    logic signed [W:0] shifted;

    always_comb begin
        n = (mag == SW'(W)) ? SW'(W - 1) : mag;
        ext = $signed({val[W-1], val});
        if (rnd && n != '0)
            bias = $signed({{W{1'b0}}, 1'b1} << (n - SW'(1)));
        else
            bias = '0;
        sum     = ext + bias;
        shifted = sum >>> n;
        res     = shifted[W-1:0];
    end
endmodule

// File: rtl/sat_word_shifter.sv
module sat_word_shifter
    import sws_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     insn,
    input  logic [XLEN-1:0] src_word,
    input  logic [XLEN-1:0] shamt_src,
    output logic            out_valid,
    output logic            out_hit,
    output logic [XLEN-1:0] out_result,
    output logic            out_sat
);
    localparam int W  = 32;
    localparam int AW = $clog2(W);
    localparam int SW = AW + 1;

    sws_op_e       op;
    logic [4:0]    imm5;
    logic [SW-1:0] amt_s;
    logic [AW-1:0] left_amt;
    logic [SW-1:0] right_mag;
    logic          go_right;
    logic          rnd;
    logic [W-1:0]  l_res;
    logic [W-1:0]  r_res;
    logic          l_sat;
    sws_state_t    st_d, st_q;

    logic unused_hi;
    assign unused_hi = ^{src_word[XLEN-1:W], shamt_src[XLEN-1:SW]};

    sws_decode u_dec (
        .insn (insn),
        .op   (op),
        .imm5 (imm5)
    );

    sws_left_sat #(.W(W)) u_left (
        .val (src_word[W-1:0]),
        .amt (left_amt),
        .res (l_res),
        .sat (l_sat)
    );

    sws_right_shift #(.W(W)) u_right (
        .val (src_word[W-1:0]),
        .mag (right_mag),
        .rnd (rnd),
        .res (r_res)
    );

    always_comb begin
        amt_s     = shamt_src[SW-1:0];
        left_amt  = '0;
        right_mag = '0;
        go_right  = 1'b0;
        rnd       = 1'b0;
        unique case (op)
            OP_BIDIR, OP_BIDIR_RND: begin
                rnd = (op == OP_BIDIR_RND);
                if (amt_s[SW-1]) begin
                    go_right  = 1'b1;
                    right_mag = '0 - amt_s;
                end else begin
                    left_amt = amt_s[AW-1:0];
                end
            end
            OP_LEFT_REG: left_amt = shamt_src[AW-1:0];
            OP_LEFT_IMM: left_amt = imm5;
            default: ;
        endcase

        st_d.vld  = in_valid;
        st_d.hit  = in_valid && (op != OP_NONE);
        st_d.sat  = st_d.hit && !go_right && l_sat;
        if (!st_d.hit)
            st_d.word = '0;
        else if (go_right)
            st_d.word = r_res;
        else
            st_d.word = l_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid  = st_q.vld;
    assign out_hit    = st_q.hit;
    assign out_sat    = st_q.sat;
    assign out_result = {{(XLEN-W){st_q.word[W-1]}}, st_q.word};

    a_r2_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_hit && !out_sat));

    a_r1_miss_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit) |-> (out_result == '0 && !out_sat));

    a_r4_sat_limit: assert property (@(posedge clk) disable iff (!rst_n)
        out_sat |-> (out_result[W-1:0] == 32'h7FFF_FFFF || out_result[W-1:0] == 32'h8000_0000));

    a_r5_right_never_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_BIDIR || op == OP_BIDIR_RND) && shamt_src[SW-1]) |=> !out_sat);

    a_r9_sat_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        out_sat |-> (out_valid && out_hit));

endmodule

// File: tb/sim_sat_word_shifter.sv
module sim_sat_word_shifter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] insn;
    logic [63:0] src_word;
    logic [63:0] shamt_src;
    logic        out_valid, out_hit, out_sat;
    logic [63:0] out_result;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic        ev, eh, es;
    logic [63:0] er;
    string       etag;

    localparam logic [6:0] F_BID  = 7'b0110111;
    localparam logic [6:0] F_BIDR = 7'b0111111;
    localparam logic [6:0] F_LREG = 7'b0010011;
    localparam logic [6:0] F_LIMM = 7'b0011011;

    always #2 clk = ~clk;

    sat_word_shifter #(.XLEN(64)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .src_word(src_word), .shamt_src(shamt_src),
        .out_valid(out_valid), .out_hit(out_hit),
        .out_result(out_result), .out_sat(out_sat)
    );

    function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] imm);
        return {f7, imm, 5'd3, 3'b001, 5'd7, 7'b1110111};
    endfunction

    task automatic model(input logic v, input logic [31:0] ins, input logic [63:0] a,
                         input logic [63:0] b, output logic mv, output logic mh,
                         output logic ms, output logic [63:0] mr);
        longint x, y;
        int     amt, n;
        bit     rnd, bid;
        mv = v; mh = 1'b0; ms = 1'b0; mr = '0;
        if (!v || ins[6:0] != 7'b1110111 || ins[14:12] != 3'b001) return;
        rnd = 0; bid = 0;
        case (ins[31:25])
            F_BID:  bid = 1;
            F_BIDR: begin bid = 1; rnd = 1; end
            F_LREG: amt = int'(b[4:0]);
            F_LIMM: amt = int'(ins[24:20]);
            default: return;
        endcase
        mh = 1'b1;
        x = longint'($signed(a[31:0]));
        if (bid) begin
            amt = int'(b[5:0]);
            if (amt > 31) amt = amt - 64;
        end
        if (amt >= 0) begin
            y = x * (longint'(1) << amt);
            if (y > 64'sd2147483647) begin y = 64'sd2147483647; ms = 1'b1; end
            else if (y < -64'sd2147483648) begin y = -64'sd2147483648; ms = 1'b1; end
        end else begin
            n = -amt;
            if (n == 32) n = 31;
            if (rnd) y = (x + (longint'(1) << (n - 1))) >>> n;
            else     y = x >>> n;
        end
        mr = 64'(y);
    endtask

    task automatic compare();
        checks++;
        if (out_valid !== ev || out_hit !== eh || out_sat !== es || out_result !== er) begin
            errors++;
            $display("FAIL %s: got v=%b h=%b s=%b r=%h exp v=%b h=%b s=%b r=%h",
                     etag, out_valid, out_hit, out_sat, out_result, ev, eh, es, er);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] ins, input logic [63:0] a,
                        input logic [63:0] b, input string tag);
        @(negedge clk);
        compare();
        in_valid = v; insn = ins; src_word = a; shamt_src = b;
        model(v, ins, a, b, ev, eh, es, er);
        etag = tag;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; insn = '0; src_word = '0; shamt_src = '0;
        ev = 0; eh = 0; es = 0; er = '0; etag = "R2 reset state";
        repeat (3) @(negedge clk);
        compare();
        rst_n = 1'b1;

        // R1: decode misses
        step(1, {7'b0110110, 5'd0, 5'd0, 3'b001, 5'd0, 7'b1110111}, 64'h4000_0000, 64'd1, "R1 bad funct7");
        step(1, {F_BID, 5'd0, 5'd0, 3'b000, 5'd0, 7'b1110111}, 64'h4000_0000, 64'd1, "R1 bad funct3");
        step(1, {F_BID, 5'd0, 5'd0, 3'b001, 5'd0, 7'b0110011}, 64'h4000_0000, 64'd1, "R1 bad opcode");
        // R2: invalid cycle with clamping operands
        step(0, mk(F_LREG, 0), 64'h7000_0000, 64'd4, "R2 idle cycle");
        // R4: left saturation
        step(1, mk(F_BID, 0), 64'h4000_0000, 64'd1, "R4 positive clamp");
        step(1, mk(F_BID, 0), 64'hFFFF_FFFF_FFFF_FFFF, 64'd31, "R4 exact min no clamp");
        step(1, mk(F_BID, 0), 64'h0000_0000_FFFF_FFFE, 64'd31, "R4 negative clamp");
        step(1, mk(F_BIDR, 0), 64'h0000_1234, 64'd0, "R4 zero amount");
        // R5: truncating right shift
        step(1, mk(F_BID, 0), 64'h8000_0000, 64'h20, "R5 magnitude 32 from min");
        step(1, mk(F_BID, 0), 64'h7FFF_FFFF, 64'h20, "R5 magnitude 32 from max");
        step(1, mk(F_BID, 0), 64'hFFFF_FFFB, 64'h3F, "R5 shift by one negative");
        // R6: rounding right shift
        step(1, mk(F_BIDR, 0), 64'd5, 64'h3F, "R6 round positive half");
        step(1, mk(F_BIDR, 0), 64'hFFFF_FFFB, 64'h3F, "R6 round negative half");
        step(1, mk(F_BIDR, 0), 64'h7FFF_FFFF, 64'h20, "R6 round magnitude 32");
        step(1, mk(F_BIDR, 0), 64'h8000_0000, 64'h20, "R6 round min magnitude 32");
        // R3: upper operand bits ignored
        step(1, mk(F_BID, 0), 64'd3, 64'hFFFF_FFFF_FFFF_FFC1, "R3 upper bits set");
        // R7: register vs immediate amount
        step(1, mk(F_LREG, 0), 64'd3, 64'h25, "R7 register low five bits");
        step(1, mk(F_LIMM, 5'd3), 64'd5, 64'hFFFF_FFFF_FFFF_FFFF, "R7 immediate ignores operand");
        // R8: upper source bits ignored, sign extension
        step(1, mk(F_LIMM, 5'd4), 64'hDEAD_BEEF_F000_0001, 64'd0, "R8 sign extension");
        // R9: back-to-back clamps then no clamp
        step(1, mk(F_LREG, 0), 64'h7000_0000, 64'd4, "R9 first pulse");
        step(1, mk(F_LIMM, 5'd8), 64'h8000_0001, 64'd0, "R9 second pulse");
        step(1, mk(F_LREG, 0), 64'd1, 64'd1, "R9 pulse ends");

        for (int i = 0; i < 400; i++) begin
            logic [6:0]  f7;
            logic [31:0] ins;
            case ($urandom % 5)
                0: f7 = F_BID;
                1: f7 = F_BIDR;
                2: f7 = F_LREG;
                3: f7 = F_LIMM;
                default: f7 = 7'($urandom);
            endcase
            ins = {f7, 5'($urandom), 5'($urandom), 3'b001, 5'($urandom), 7'b1110111};
            step(($urandom % 8) != 0, ins, {$urandom, $urandom}, {$urandom, $urandom},
                 "R3 R4 R5 R6 R7 random mix");
        end
        step(0, '0, '0, '0, "R2 drain");
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule